// File: doc/BRIEF.md
# External Interrupt Input Conditioner

This block turns raw port-pin levels into interrupt-pending flags for an interrupt controller. It has two channels, and they do not interact. Each channel picks one line of an 8-bit port bus through its own pin-select field. The channel only reads that line, so any other logic driving or using the pin is unaffected. The selected line passes through a two-flop synchronizer before the channel evaluates it.

Each channel has two configuration bits, which give four detection styles. A detect-mode bit chooses between edge detection (1) and level detection (0). An active-polarity bit chooses active-high (1) or active-low (0).

- In edge mode, the active transition sets a sticky flag. The transition is rising for active-high and falling for active-low. The flag is cleared by the per-channel vector-acknowledge pulse that the interrupt controller issues when it enters the service routine.
- In level mode, the pending output simply reports whether the synchronized pin is at its active level. It holds no state.

Changing the configuration, or leaving reset, re-seeds the edge history. A stable pin therefore never produces a false edge.

Top module: `ext_irq_cond`

## Requirements
- R1: While `rst_n` is low, `pend` is 0 for channels in edge mode. After `rst_n` rises, a pin level held steady through reset does not set any edge-mode flag.
- R2: `det_mode[i]`=1 selects edge detection and 0 selects level detection for channel i. `act_pol[i]`=1 selects active-high and 0 selects active-low.
- R3: In level mode, `pend[i]` is 1 exactly when the selected pin is at its active level. The output follows a pin change two clock edges later, holds no memory, and is not affected by `vec_ack`.
- R4: In edge mode, the active transition of the selected pin sets `pend[i]` on the third clock edge after the pin change. `pend[i]` stays set after the pin returns. The opposite transition never sets it.
- R5: In edge mode, a one-cycle `vec_ack[i]` clears `pend[i]` at the clock edge that samples it.
- R6: If an active edge is detected in the same cycle as `vec_ack[i]`, `pend[i]` remains 1.
- R7: Channel i observes only port bit `pin_sel[i]` (a 3-bit index, bit 0 = `port_pins[0]`). Activity on other port bits has no effect on it.
- R8: A change of `det_mode`, `act_pol` or `pin_sel` on a channel does not by itself set that channel's edge flag.
- R9: The channels are independent: `vec_ack` of one channel does not clear the other, and each keeps its own configuration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously to `clk` |
| port_pins | input | 8 | Raw asynchronous port bus |
| det_mode | input | 2 | Per channel: 1 edge, 0 level |
| act_pol | input | 2 | Per channel: 1 active-high, 0 active-low |
| pin_sel | input | 2x3 | Per channel: index of the observed port bit |
| vec_ack | input | 2 | Per channel vector-acknowledge pulse |
| pend | output | 2 | Per channel interrupt-pending flag |

## Verification
The main function is driven with four kinds of pin pattern:
- **Rising and falling transitions under both polarities.** These separate the active direction from the inactive one.
- **Level sequences that go active, inactive and active again.** These show that level mode has no memory and ignores the acknowledge.
- **Activity on unselected port bits and moves of the select field.** These show that each channel reads only its own pin.
- **Configuration changes while the pins are steady, and a pin held high through reset.** These show that neither case produces a false edge.

Directed steps also check that an active edge arriving together with the acknowledge keeps the flag set, and that an acknowledge on one channel leaves the other alone. They also check the exact latencies: two clock edges for level mode and three for edge mode.

// File: rtl/eic_pkg.sv
package eic_pkg;
  typedef enum logic {DET_LEVEL = 1'b0, DET_EDGE = 1'b1} det_e;
  typedef enum logic {POL_LOW = 1'b0, POL_HIGH = 1'b1} pol_e;

  // Active transition test for a given polarity.
  function automatic logic active_edge(logic pol, logic cur, logic prev);
    return pol ? (cur & ~prev) : (~cur & prev);
  endfunction
endpackage

// File: rtl/eic_sync.sv
module eic_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage_q [STAGES];
  logic [W-1:0] stage_d [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_comb stage_d[s] = d_i;
      end else begin : g_next
        always_comb stage_d[s] = stage_q[s-1];
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= '0;
        else        stage_q[s] <= stage_d[s];
      end
    end
  endgenerate

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/eic_arm.sv
module eic_arm #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic arm_o
);
  // Detection waits until the synchronizer and the edge history hold real pin data.
  localparam int LIMIT = STAGES + 1;
  localparam int CW    = $clog2(LIMIT + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign arm_o  = (cnt_q == CW'(LIMIT));
  assign cnt_en = !arm_o;

  always_comb begin
    cnt_d = cnt_q;
    if (cnt_en) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // Once armed, detection stays enabled until the next reset (R1).
  assert_arm_sticky_R1: assert property (@(posedge clk) disable iff (!rst_n)
    arm_o |=> arm_o);
endmodule

// File: rtl/eic_channel.sv
module eic_channel
  import eic_pkg::*;
#(
  parameter int PORT_W = 8,
  parameter int SELW   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              arm_i,
  input  logic [PORT_W-1:0] port_i,
  input  logic [SELW-1:0]   sel_i,
  input  logic              mode_i,
  input  logic              pol_i,
  input  logic              ack_i,
  output logic              pend_o
);
  localparam int CFGW = SELW + 2;

  logic            pin_bit;
  logic [CFGW-1:0] cfg_now, cfg_q;
  logic            prev_q, prev_d;
  logic            flag_q, flag_d;
  logic            cfg_same, hit;

  // Observe-only pin pick; out-of-range indices read as inactive-low zero.
  always_comb begin
    pin_bit = 1'b0;
    if (int'(sel_i) < PORT_W) pin_bit = port_i[sel_i];
  end

  assign cfg_now  = {sel_i, mode_i, pol_i};
  assign cfg_same = (cfg_now == cfg_q);

  assign hit = arm_i && cfg_same && (det_e'(mode_i) == DET_EDGE)
               && active_edge(pol_i, pin_bit, prev_q);

  always_comb begin
    prev_d = pin_bit;
    flag_d = 1'b0;
    if (det_e'(mode_i) == DET_EDGE) flag_d = hit | (flag_q & ~ack_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= '0;
      prev_q <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      cfg_q  <= cfg_now;
      prev_q <= prev_d;
      flag_q <= flag_d;
    end
  end

  assign pend_o = (det_e'(mode_i) == DET_EDGE) ? flag_q : (pin_bit == pol_i);

  // A flag only ever rises from a detected active edge (R4).
  assert_rise_from_edge_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> $past(hit));

  // Acknowledge without a new edge clears the flag (R5).
  assert_ack_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i && ack_i && !hit) |=> !flag_q);

  // Edge coinciding with acknowledge is kept (R6).
  assert_ack_keeps_edge_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i && hit && ack_i) |=> flag_q);

  // A configuration change alone never raises the flag (R8).
  assert_no_cfg_edge_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_same && !flag_q) |=> !flag_q);
endmodule

// File: rtl/ext_irq_cond.sv
module ext_irq_cond #(
  parameter int NCH         = 2,
  parameter int PORT_W      = 8,
  parameter int SYNC_STAGES = 2,
  localparam int SELW       = (PORT_W > 1) ? $clog2(PORT_W) : 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [PORT_W-1:0]         port_pins,
  input  logic [NCH-1:0]            det_mode,
  input  logic [NCH-1:0]            act_pol,
  input  logic [NCH-1:0][SELW-1:0]  pin_sel,
  input  logic [NCH-1:0]            vec_ack,
  output logic [NCH-1:0]            pend
);
  logic [PORT_W-1:0] pins_s;
  logic              armed;

  eic_sync #(.W(PORT_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (port_pins),
    .q_o   (pins_s)
  );

  eic_arm #(.STAGES(SYNC_STAGES)) u_arm (
    .clk   (clk),
    .rst_n (rst_n),
    .arm_o (armed)
  );

  generate
    for (genvar c = 0; c < NCH; c++) begin : g_ch
      eic_channel #(.PORT_W(PORT_W), .SELW(SELW)) u_ch (
        .clk    (clk),
        .rst_n  (rst_n),
        .arm_i  (armed),
        .port_i (pins_s),
        .sel_i  (pin_sel[c]),
        .mode_i (det_mode[c]),
        .pol_i  (act_pol[c]),
        .ack_i  (vec_ack[c]),
        .pend_o (pend[c])
      );
    end
  endgenerate
endmodule

// File: tb/sim_ext_irq_cond.sv
`timescale 1ns/1ps
module sim_ext_irq_cond;
  logic            clk = 1'b0;
  logic            rst_n;
  logic [7:0]      port_pins;
  logic [1:0]      det_mode, act_pol, vec_ack, pend;
  logic [1:0][2:0] pin_sel;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  ext_irq_cond u0 (
    .clk(clk), .rst_n(rst_n), .port_pins(port_pins), .det_mode(det_mode),
    .act_pol(act_pol), .pin_sel(pin_sel), .vec_ack(vec_ack), .pend(pend)
  );

  typedef struct packed {
    logic [7:0] pins;
    logic [1:0] mode;
    logic [1:0] pol;
    logic [2:0] s0;
    logic [2:0] s1;
    logic [1:0] ack;
    logic [1:0] exp_a;
    logic [1:0] exp_b;
  } row_t;

  localparam int NROW = 17;
  localparam row_t TBL [NROW] = '{
    '{8'h01, 2'b11, 2'b11, 3'd0, 3'd1, 2'b00, 2'b01, 2'b01},
    '{8'h00, 2'b11, 2'b11, 3'd0, 3'd1, 2'b01, 2'b01, 2'b00},
    '{8'h02, 2'b11, 2'b11, 3'd0, 3'd1, 2'b01, 2'b10, 2'b10},
    '{8'h03, 2'b11, 2'b11, 3'd0, 3'd1, 2'b10, 2'b11, 2'b01},
    '{8'h03, 2'b11, 2'b00, 3'd0, 3'd1, 2'b11, 2'b01, 2'b00},
    '{8'h01, 2'b11, 2'b00, 3'd0, 3'd1, 2'b10, 2'b10, 2'b00},
    '{8'h00, 2'b11, 2'b00, 3'd0, 3'd1, 2'b00, 2'b01, 2'b01},
    '{8'h00, 2'b00, 2'b00, 3'd0, 3'd1, 2'b11, 2'b11, 2'b11},
    '{8'h03, 2'b00, 2'b00, 3'd0, 3'd1, 2'b00, 2'b00, 2'b00},
    '{8'h03, 2'b00, 2'b11, 3'd0, 3'd1, 2'b11, 2'b11, 2'b11},
    '{8'hFC, 2'b00, 2'b11, 3'd0, 3'd1, 2'b00, 2'b00, 2'b00},
    '{8'hFC, 2'b00, 2'b11, 3'd7, 3'd2, 2'b00, 2'b11, 2'b11},
    '{8'hFC, 2'b11, 2'b11, 3'd7, 3'd2, 2'b00, 2'b00, 2'b00},
    '{8'h7C, 2'b11, 2'b11, 3'd7, 3'd2, 2'b00, 2'b00, 2'b00},
    '{8'hFC, 2'b11, 2'b11, 3'd7, 3'd2, 2'b01, 2'b01, 2'b00},
    '{8'hFB, 2'b01, 2'b00, 3'd7, 3'd2, 2'b11, 2'b10, 2'b10},
    '{8'h7B, 2'b01, 2'b00, 3'd7, 3'd2, 2'b01, 2'b11, 2'b10}
  };

  function automatic string row_tag(int i);
    case (i)
      0, 3:       return "R4 active rise";
      1:          return "R5 ack clear";
      2:          return "R9 independent ack";
      4:          return "R8 polarity change";
      5, 6:       return "R2 active-low edge";
      7, 9:       return "R3 level ignores ack";
      8:          return "R2 active-low level";
      10:         return "R7 unselected pins";
      11:         return "R7 new select";
      12:         return "R8 mode change";
      13:         return "R4 opposite edge";
      14:         return "R4 rise on pin 7";
      default:    return "R9 mixed modes";
    endcase
  endfunction

  task automatic chk(string tag, logic [1:0] got, logic [1:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got=%b exp=%b at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n     = 1'b0;
    port_pins = 8'hFF;
    det_mode  = 2'b11;
    act_pol   = 2'b11;
    pin_sel   = {3'd1, 3'd0};
    vec_ack   = 2'b00;
    tick(3);
    chk("R1 reset state", pend, 2'b00);
    rst_n = 1'b1;
    tick(8);
    chk("R1 pins high through reset", pend, 2'b00);

    port_pins = 8'h00;
    tick(4);
    chk("R4 falling edge with active-high", pend, 2'b00);

    for (int i = 0; i < NROW; i++) begin
      port_pins = TBL[i].pins;
      det_mode  = TBL[i].mode;
      act_pol   = TBL[i].pol;
      pin_sel   = {TBL[i].s1, TBL[i].s0};
      vec_ack   = 2'b00;
      tick(4);
      chk(row_tag(i), pend, TBL[i].exp_a);
      vec_ack = TBL[i].ack;
      tick(1);
      vec_ack = 2'b00;
      chk({row_tag(i), " after ack"}, pend, TBL[i].exp_b);
    end

    // Back to edge, active-high, pins 0/1 (R8: no flag from the switch).
    det_mode  = 2'b11;
    act_pol   = 2'b11;
    pin_sel   = {3'd1, 3'd0};
    port_pins = 8'h00;
    tick(4);
    chk("R8 reconfigure to edge", pend, 2'b00);

    // Edge latency: three clock edges (R4).
    port_pins = 8'h01;
    tick(2);
    chk("R4 not yet after two edges", pend, 2'b00);
    tick(1);
    chk("R4 set on third edge", pend, 2'b01);
    port_pins = 8'h00;
    tick(4);
    chk("R4 held after pin returns", pend, 2'b01);

    // New edge together with ack (R6).
    port_pins = 8'h01;
    tick(2);
    vec_ack = 2'b01;
    tick(1);
    vec_ack = 2'b00;
    chk("R6 edge with ack kept", pend, 2'b01);
    vec_ack = 2'b01;
    tick(1);
    vec_ack = 2'b00;
    chk("R5 ack alone clears", pend, 2'b00);

    // Level latency and lack of memory (R3).
    det_mode  = 2'b00;
    act_pol   = 2'b11;
    port_pins = 8'h00;
    tick(4);
    chk("R3 level inactive", pend, 2'b00);
    port_pins = 8'h02;
    tick(1);
    chk("R3 level after one edge", pend, 2'b00);
    tick(1);
    chk("R3 level after two edges", pend, 2'b10);
    port_pins = 8'h00;
    tick(2);
    chk("R3 level drops with pin", pend, 2'b00);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule